// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Per-Frame Status Queue

This block is the receive side of an asynchronous serial port. It takes a 16x oversampling tick from an external baud generator and synchronises the serial input. It finds start bits, takes a majority vote near the middle of every bit, and assembles each character in a shift register. A finished character moves into a two-entry queue. Each entry carries its own framing-error, parity-error and overrun bits, so the status a host reads always belongs to the character it is about to pop.

The host sees the oldest unread character and its three status bits on plain outputs. It pulses a pop input to discard that character and expose the next one. A level receive-complete output stays high while anything is unread, and a separate request output asks for service while that flag and its enable are both high. Deasserting the enable input stops reception at once and empties every stored character.

Top module: `uart_rx_buf`

## Requirements
- R1: After reset, `rxc_o`, `irq_o`, `data_o`, `fe_o`, `pe_o` and `dor_o` are all 0.
- R2: A frame is a low start bit, DATA_W data bits LSB first, one parity bit only while `par_en_i` is 1, then a stop bit. Each bit is the majority of oversampling ticks 7, 8 and 9 counted from the first low tick. A completed character appears on `data_o`.
- R3: A low level that is not still low by majority on ticks 7 to 9 is discarded, and the receiver waits for a new falling level.
- R4: `fe_o` is 1 for a character whose first stop bit was sampled low and 0 when it was sampled high. Later stop bits are not examined.
- R5: With `par_en_i`=1 and `par_odd_i`=0 the expected parity bit is the XOR of the data bits. With `par_odd_i`=1 it is the inverse of that XOR. A mismatch sets `pe_o` for that character. With `par_en_i`=0, `pe_o` is 0.
- R6: Characters are read in arrival order. The queue holds two of them, and a third may wait finished in the shift register until a slot frees. `fe_o`, `pe_o` and `dor_o` describe the character currently on `data_o`.
- R7: A confirmed start bit while both queue slots are full and a finished character waits in the shift register is an overrun. The waiting character is lost, and the next character stored carries `dor_o`=1. Characters stored after it carry `dor_o`=0.
- R8: `rxc_o` is 1 exactly while unread data exists. A pop of the last character clears it. A pop while empty changes nothing. While empty, `data_o` and the flags read 0.
- R9: `irq_o` is 1 only while `rxc_o` and `rxc_ie_i` are both 1. Error flags alone never raise it.
- R10: With `en_i`=0, the reception in progress is abandoned and all stored characters are dropped on the next clock. Line activity while disabled stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | Oversampling strobe, 16 per bit time |
| rx_i | input | 1 | Serial line, idle high |
| en_i | input | 1 | Receiver enable |
| par_en_i | input | 1 | Parity bit present and checked |
| par_odd_i | input | 1 | 1 selects odd parity, 0 even |
| rxc_ie_i | input | 1 | Request enable |
| data_rd_i | input | 1 | Pop the oldest character |
| data_o | output | DATA_W | Oldest unread character |
| fe_o | output | 1 | Framing error of that character |
| pe_o | output | 1 | Parity error of that character |
| dor_o | output | 1 | Overrun marker of that character |
| rxc_o | output | 1 | Unread data present |
| irq_o | output | 1 | Service request |

## Verification
The bench sends characters with alternating and asymmetric bit patterns such as 0xA5, 0x01 and 0x80, so that a bit-order or off-by-one sampling fault changes the value seen. A frame with a low stop bit and frames with a correct or flipped parity bit, in both parity senses, separate the flag paths from the data path. A run of three characters without reads, and then a run of four, separates plain queueing from the overrun case: the discarded third character and the overrun mark on the fourth appear at the ports. A short low glitch, a pop on an empty queue and a disable in the middle of a frame check that none of them leaves data or status behind.

// File: rtl/uart_rx_pkg.sv
`timescale 1ns/1ps
package uart_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic dor;
    logic pe;
    logic fe;
  } rx_flags_t;

  localparam int unsigned FLAGS_W = $bits(rx_flags_t);
endpackage

// File: rtl/uart_rx_sampler.sv
`timescale 1ns/1ps
module uart_rx_sampler
  import uart_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OSR    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  output logic              start_ok_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              fe_o,
  output logic              pe_o
);
  localparam int unsigned CW = $clog2(OSR);
  localparam int unsigned IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] A_IDX = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] B_IDX = CW'(OSR/2);
  localparam logic [CW-1:0] V_IDX = CW'(OSR/2 + 1);
  localparam logic [CW-1:0] L_IDX = CW'(OSR - 1);
  localparam logic [IW-1:0] LAST  = IW'(DATA_W - 1);

  rx_state_e         state_q;
  logic [CW-1:0]     cnt_q;
  logic [IW-1:0]     idx_q;
  logic              s_a_q, s_b_q;
  logic [DATA_W-1:0] shift_q;
  logic              acc_q, pbit_q, par_used_q;
  logic              vote;

  assign vote = (s_a_q & s_b_q) | (s_a_q & rx_i) | (s_b_q & rx_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      idx_q      <= '0;
      s_a_q      <= 1'b1;
      s_b_q      <= 1'b1;
      shift_q    <= '0;
      acc_q      <= 1'b0;
      pbit_q     <= 1'b0;
      par_used_q <= 1'b0;
      start_ok_o <= 1'b0;
      done_o     <= 1'b0;
      data_o     <= '0;
      fe_o       <= 1'b0;
      pe_o       <= 1'b0;
    end else if (!en_i) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      start_ok_o <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      start_ok_o <= 1'b0;
      done_o     <= 1'b0;
      if (tick_i) begin
        if (state_q == ST_IDLE) begin
          if (!rx_i) begin
            state_q <= ST_START;
            cnt_q   <= CW'(1);
            idx_q   <= '0;
            acc_q   <= 1'b0;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == A_IDX) s_a_q <= rx_i;
          if (cnt_q == B_IDX) s_b_q <= rx_i;
          if (cnt_q == V_IDX) begin
            case (state_q)
              ST_START: begin
                if (vote) begin
                  state_q <= ST_IDLE;
                  cnt_q   <= '0;
                end else begin
                  start_ok_o <= 1'b1;
                end
              end
              ST_DATA: begin
                shift_q <= {vote, shift_q[DATA_W-1:1]};
                acc_q   <= acc_q ^ vote;
              end
              ST_PAR: pbit_q <= vote;
              ST_STOP: begin
                // finish at mid-stop so the next start edge is not missed
                done_o  <= 1'b1;
                data_o  <= shift_q;
                fe_o    <= !vote;
                pe_o    <= par_used_q & (acc_q ^ pbit_q ^ par_odd_i);
                state_q <= ST_IDLE;
                cnt_q   <= '0;
              end
              default: ;
            endcase
          end
          if (cnt_q == L_IDX) begin
            cnt_q <= '0;
            case (state_q)
              ST_START: state_q <= ST_DATA;
              ST_DATA: begin
                if (idx_q == LAST) begin
                  par_used_q <= par_en_i;
                  state_q    <= par_en_i ? ST_PAR : ST_STOP;
                end else begin
                  idx_q <= idx_q + 1'b1;
                end
              end
              ST_PAR:  state_q <= ST_STOP;
              default: ;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_fifo.sv
`timescale 1ns/1ps
module uart_rx_fifo #(
  parameter int unsigned WIDTH = 11,
  parameter int unsigned DEPTH = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         flush_i,
  input  logic                         push_i,
  input  logic [WIDTH-1:0]             wdata_i,
  input  logic                         pop_i,
  output logic [WIDTH-1:0]             rdata_o,
  output logic                         empty_o,
  output logic                         full_o,
  output logic [$clog2(DEPTH+1)-1:0]   cnt_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned NW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] PMAX = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_q, rd_q;
  logic [NW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == NW'(DEPTH));
  assign cnt_o   = cnt_q;
  assign rdata_o = mem_q[rd_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   mem_q[g] <= '0;
      else if (do_push && !flush_i && wr_q == AW'(g)) mem_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == PMAX) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == PMAX) ? '0 : rd_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/uart_rx_buf.sv
`timescale 1ns/1ps
module uart_rx_buf
  import uart_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OSR    = 16,
  parameter int unsigned DEPTH  = 2,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick16_i,
  input  logic              rx_i,
  input  logic              en_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              rxc_ie_i,
  input  logic              data_rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              fe_o,
  output logic              pe_o,
  output logic              dor_o,
  output logic              rxc_o,
  output logic              irq_o
);
  localparam int unsigned EW = DATA_W + FLAGS_W;
  localparam int unsigned NW = $clog2(DEPTH+1);

  logic [SYNC_N-1:0] sync_q;
  logic              rx_s;
  logic              smp_start_ok, smp_done, smp_fe, smp_pe;
  logic [DATA_W-1:0] smp_data;

  logic              sr_valid, sr_fe, sr_pe, sr_dor, ovr_pend;
  logic [DATA_W-1:0] sr_data;

  logic              fifo_push, fifo_empty, fifo_full;
  logic [EW-1:0]     fifo_wdata, fifo_rdata;
  logic [NW-1:0]     fifo_cnt;
  rx_flags_t         wr_flags, head_flags;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_N-2:0], rx_i};
  end
  assign rx_s = sync_q[SYNC_N-1];

  uart_rx_sampler #(.DATA_W(DATA_W), .OSR(OSR)) u_sampler (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .tick_i     (tick16_i),
    .rx_i       (rx_s),
    .par_en_i   (par_en_i),
    .par_odd_i  (par_odd_i),
    .start_ok_o (smp_start_ok),
    .done_o     (smp_done),
    .data_o     (smp_data),
    .fe_o       (smp_fe),
    .pe_o       (smp_pe)
  );

  // holding stage: the finished character waiting for a free queue slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_valid <= 1'b0;
      sr_data  <= '0;
      sr_fe    <= 1'b0;
      sr_pe    <= 1'b0;
      sr_dor   <= 1'b0;
      ovr_pend <= 1'b0;
    end else if (!en_i) begin
      sr_valid <= 1'b0;
      sr_dor   <= 1'b0;
      ovr_pend <= 1'b0;
    end else begin
      if (smp_start_ok && fifo_full && sr_valid) begin
        sr_valid <= 1'b0;
        ovr_pend <= 1'b1;
      end else if (fifo_push) begin
        sr_valid <= 1'b0;
      end
      if (smp_done) begin
        sr_valid <= 1'b1;
        sr_data  <= smp_data;
        sr_fe    <= smp_fe;
        sr_pe    <= smp_pe;
        sr_dor   <= ovr_pend;
        ovr_pend <= 1'b0;
      end
    end
  end

  assign fifo_push  = en_i && sr_valid && !fifo_full;
  assign wr_flags   = '{dor: sr_dor, pe: sr_pe, fe: sr_fe};
  assign fifo_wdata = {wr_flags, sr_data};

  uart_rx_fifo #(.WIDTH(EW), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (!en_i),
    .push_i  (fifo_push),
    .wdata_i (fifo_wdata),
    .pop_i   (data_rd_i),
    .rdata_o (fifo_rdata),
    .empty_o (fifo_empty),
    .full_o  (fifo_full),
    .cnt_o   (fifo_cnt)
  );

  assign head_flags = fifo_empty ? '0 : rx_flags_t'(fifo_rdata[EW-1:DATA_W]);
  assign data_o     = fifo_empty ? '0 : fifo_rdata[DATA_W-1:0];
  assign fe_o       = head_flags.fe;
  assign pe_o       = head_flags.pe;
  assign dor_o      = head_flags.dor;
  assign rxc_o      = !fifo_empty;
  assign irq_o      = rxc_o && rxc_ie_i;
endmodule

// File: rtl/uart_rx_buf_chk.sv
`timescale 1ns/1ps
module uart_rx_buf_chk #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned NW    = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          rxc_ie_i,
  input logic          data_rd_i,
  input logic          rxc_o,
  input logic          irq_o,
  input logic [NW-1:0] fifo_cnt,
  input logic          fifo_push,
  input logic          fifo_full,
  input logic          sr_valid,
  input logic          smp_start_ok
);
  p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= NW'(DEPTH));

  p_flush_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !rxc_o);

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rxc_o && !data_rd_i && en_i) |=> rxc_o);

  p_pop_last_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rxc_o && data_rd_i && fifo_cnt == NW'(1) && !fifo_push) |=> !rxc_o);

  p_irq_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (rxc_o && rxc_ie_i));

  p_ovr_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && smp_start_ok && fifo_full && sr_valid) |=> !sr_valid);
endmodule

bind uart_rx_buf uart_rx_buf_chk #(.DEPTH(DEPTH), .NW(NW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .rxc_ie_i     (rxc_ie_i),
  .data_rd_i    (data_rd_i),
  .rxc_o        (rxc_o),
  .irq_o        (irq_o),
  .fifo_cnt     (fifo_cnt),
  .fifo_push    (fifo_push),
  .fifo_full    (fifo_full),
  .sr_valid     (sr_valid),
  .smp_start_ok (smp_start_ok)
);

// File: tb/uart_rx_buf_bench.sv
`timescale 1ns/1ps
module uart_rx_buf_bench;
  localparam int BIT_CLKS = 32;  // tick every 2 clocks, 16 ticks per bit

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rx = 1'b1;
  logic       en = 1'b0;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       ie = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] data;
  logic       fe, pe, dor, rxc, irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  uart_rx_buf u_uart_rx_buf (
    .clk_i(clk), .rst_ni(rst_n), .tick16_i(tick), .rx_i(rx), .en_i(en),
    .par_en_i(par_en), .par_odd_i(par_odd), .rxc_ie_i(ie), .data_rd_i(rd),
    .data_o(data), .fe_o(fe), .pe_o(pe), .dor_o(dor), .rxc_o(rxc), .irq_o(irq)
  );

  initial begin
    forever begin
      @(negedge clk);
      tick = ~tick;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send_bit(input logic v);
    rx = v;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit has_par, input logic pbit,
                            input logic stop_v);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    if (has_par) send_bit(pbit);
    send_bit(stop_v);
    send_bit(1'b1);
  endtask

  task automatic pop();
    @(negedge clk);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_head(input string req, input int d, input int f, input int p, input int o);
    chk(req, "rxc", int'(rxc), 1);
    chk(req, "data", int'(data), d);
    chk(req, "fe", int'(fe), f);
    chk(req, "pe", int'(pe), p);
    chk(req, "dor", int'(dor), o);
  endtask

  task automatic t_reset();
    chk("R1", "rxc", int'(rxc), 0);
    chk("R1", "irq", int'(irq), 0);
    chk("R1", "data", int'(data), 0);
    chk("R1", "flags", int'({fe, pe, dor}), 0);
  endtask

  task automatic t_basic();
    send_frame(8'hA5, 0, 0, 1);
    chk_head("R2", 'hA5, 0, 0, 0);
    pop();
    chk("R8", "rxc after last pop", int'(rxc), 0);
    chk("R8", "data when empty", int'(data), 0);
    send_frame(8'h01, 0, 0, 1);
    chk_head("R2", 'h01, 0, 0, 0);
    pop();
    send_frame(8'h80, 0, 0, 1);
    chk_head("R2", 'h80, 0, 0, 0);
    pop();
  endtask

  task automatic t_false_start();
    rx = 1'b0;
    repeat (8) @(negedge clk);
    rx = 1'b1;
    repeat (3 * BIT_CLKS) @(negedge clk);
    chk("R3", "rxc after glitch", int'(rxc), 0);
    send_frame(8'h5A, 0, 0, 1);
    chk_head("R3", 'h5A, 0, 0, 0);
    pop();
  endtask

  task automatic t_frame_err();
    send_frame(8'hC3, 0, 0, 0);
    repeat (BIT_CLKS) @(negedge clk);
    chk_head("R4", 'hC3, 1, 0, 0);
    pop();
    chk("R4", "no extra char after low stop", int'(rxc), 0);
  endtask

  task automatic t_parity();
    par_en = 1'b1;
    par_odd = 1'b0;
    send_frame(8'h37, 1, ^8'h37, 1);
    chk_head("R5", 'h37, 0, 0, 0);
    pop();
    send_frame(8'h37, 1, ~(^8'h37), 1);
    chk_head("R5", 'h37, 0, 1, 0);
    pop();
    par_odd = 1'b1;
    send_frame(8'h96, 1, ~(^8'h96), 1);
    chk_head("R5", 'h96, 0, 0, 0);
    pop();
    send_frame(8'h96, 1, ^8'h96, 1);
    chk_head("R5", 'h96, 0, 1, 0);
    pop();
    par_en = 1'b0;
    send_frame(8'h96, 0, 0, 1);
    chk_head("R5", 'h96, 0, 0, 0);
    pop();
    par_odd = 1'b0;
  endtask

  task automatic t_order();
    send_frame(8'h11, 0, 0, 0);
    send_frame(8'h22, 0, 0, 1);
    send_frame(8'h33, 0, 0, 1);
    chk_head("R6", 'h11, 1, 0, 0);
    pop();
    chk_head("R6", 'h22, 0, 0, 0);
    pop();
    chk_head("R6", 'h33, 0, 0, 0);
    pop();
    chk("R6", "rxc drained", int'(rxc), 0);
  endtask

  task automatic t_overrun();
    send_frame(8'h41, 0, 0, 1);
    send_frame(8'h42, 0, 0, 1);
    send_frame(8'h43, 0, 0, 1);
    send_frame(8'h44, 0, 0, 1);
    chk_head("R7", 'h41, 0, 0, 0);
    pop();
    chk_head("R7", 'h42, 0, 0, 0);
    pop();
    chk_head("R7", 'h44, 0, 0, 1);
    pop();
    chk("R7", "third char lost", int'(rxc), 0);
    send_frame(8'h45, 0, 0, 1);
    chk_head("R7", 'h45, 0, 0, 0);
    pop();
  endtask

  task automatic t_irq_pop_empty();
    pop();
    chk("R8", "pop on empty rxc", int'(rxc), 0);
    chk("R8", "pop on empty data", int'(data), 0);
    ie = 1'b0;
    send_frame(8'h6E, 0, 0, 0);
    repeat (BIT_CLKS) @(negedge clk);
    chk("R9", "irq with flags but ie=0", int'(irq), 0);
    chk("R9", "fe present", int'(fe), 1);
    ie = 1'b1;
    @(negedge clk);
    chk("R9", "irq with ie=1", int'(irq), 1);
    pop();
    chk("R9", "irq after drain", int'(irq), 0);
  endtask

  task automatic t_disable();
    send_frame(8'h99, 0, 0, 1);
    chk("R10", "char stored", int'(rxc), 1);
    send_bit(1'b0);
    send_bit(1'b1);
    send_bit(1'b0);
    en = 1'b0;
    @(negedge clk);
    chk("R10", "rxc after disable", int'(rxc), 0);
    chk("R10", "irq after disable", int'(irq), 0);
    rx = 1'b1;
    send_frame(8'h77, 0, 0, 1);
    en = 1'b1;
    repeat (2 * BIT_CLKS) @(negedge clk);
    chk("R10", "nothing kept from disabled period", int'(rxc), 0);
    send_frame(8'h3C, 0, 0, 1);
    chk_head("R10", 'h3C, 0, 0, 0);
    pop();
    ie = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    en = 1'b1;
    ie = 1'b1;
    repeat (BIT_CLKS) @(negedge clk);
    t_basic();
    t_false_start();
    t_frame_err();
    t_parity();
    t_order();
    t_overrun();
    t_irq_pop_empty();
    t_disable();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule